// File: doc/BRIEF.md
# Branch and Jump Next-PC Unit

This block decides where a 32-bit load/store processor fetches next. Given the address of the current instruction, a decoded control-flow class, the two source register values, the 16-bit branch offset field and the 26-bit jump field, it produces the next fetch address in the same cycle. It also flags whether the flow was redirected and whether a return address must be written. It is purely combinational and sits between decode and the fetch address register.

Four target forms are covered. Conditional branches add a signed word offset to the sequential address. Region jumps keep the top bits of the sequential address and replace the rest with the jump field. Register jumps take the address from a source register. Linking forms ask for the sequential address to be written as a return address. Delay slots, fetch and the register file belong to other blocks.

Top module: `nextpc_unit`

## Requirements
- R1: The class input `flow_cls` is 4 bits: 0 none, 1 branch-if-equal, 2 branch-if-not-equal, 3 branch if `rs_val` >= 0, 4 branch if > 0, 5 branch if <= 0, 6 branch if < 0, 7 linking branch if >= 0, 8 linking branch if < 0, 9 region jump, 10 linking region jump, 11 register jump, 12 linking register jump. Class 0 and the unused codes 13 to 15 give `next_pc` = `pc` + 4, `taken` = 0 and `link_we` = 0.
- R2: Class 1 is taken exactly when `rs_val` equals `rt_val`, and class 2 exactly when they differ.
- R3: Classes 3 to 8 read `rs_val` as a two's-complement signed value and compare it with zero, using the relation given for each class in R1.
- R4: When a branch is taken, `next_pc` = `pc` + 4 + (sign-extended `br_off` shifted left by 2). This holds for forward offsets, backward offsets and the most negative offset 0x8000.
- R5: When a branch is not taken, `next_pc` = `pc` + 4, `taken` = 0 and `link_we` = 0.
- R6: Classes 9 and 10 always set `taken`. Their `next_pc` is bits 31..28 of `pc` + 4, then `jmp_idx`, then two zero bits.
- R7: Classes 11 and 12 always set `taken`, and `next_pc` equals `rs_val`.
- R8: `link_we` is 1 for classes 10 and 12, and for classes 7 and 8 when taken. `link_data` is always `pc` + 4, wrapping modulo 2^32.
- R9: A linking branch whose condition fails asserts neither `link_we` nor `taken`. The bench checks this by observing `link_we` and `next_pc`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pc | input | 32 | Address of the current instruction |
| flow_cls | input | 4 | Decoded control-flow class (codes in R1) |
| rs_val | input | 32 | First source register value |
| rt_val | input | 32 | Second source register value |
| br_off | input | 16 | Branch word offset field |
| jmp_idx | input | 26 | Region jump word index field |
| next_pc | output | 32 | Next fetch address |
| taken | output | 1 | Flow redirected away from the sequential address |
| link_we | output | 1 | Return address must be written |
| link_data | output | 32 | Return address value |

## Verification
The embedded assertions check several relations whenever the inputs change. An untaken result must point at the sequential address. A link request must come with a redirect. A taken equality branch must see equal operands, and a taken less-than-zero branch must see a negative operand. A region jump must keep the upper bits of the sequential address. What the assertions cannot show is the arithmetic of each target. That includes the sign extension of the largest backward offset, the carry of the sequential address into the region bits, and a jump from a high region. Only the bench's vectors, with their independently worked results, show these.

// File: rtl/nextpc_pkg.sv
package nextpc_pkg;
   typedef enum logic [3:0] {
      FC_NONE   = 4'd0,
      FC_BEQ    = 4'd1,
      FC_BNE    = 4'd2,
      FC_GEZ    = 4'd3,
      FC_GTZ    = 4'd4,
      FC_LEZ    = 4'd5,
      FC_LTZ    = 4'd6,
      FC_GEZ_LK = 4'd7,
      FC_LTZ_LK = 4'd8,
      FC_JREG   = 4'd9,
      FC_JREG_LK= 4'd10,
      FC_JIND   = 4'd11,
      FC_JIND_LK= 4'd12
   } flow_cls_e;

   typedef enum logic [1:0] {
      SRC_SEQ  = 2'd0,
      SRC_REL  = 2'd1,
      SRC_REGN = 2'd2,
      SRC_IND  = 2'd3
   } tgt_src_e;
endpackage

// File: rtl/nextpc_cond.sv
module nextpc_cond
   import nextpc_pkg::*;
#(
   parameter int XLEN     = 32,
   parameter int EQ_STYLE = 0
) (
   input  flow_cls_e        cls,
   input  logic [XLEN-1:0]  a_val,
   input  logic [XLEN-1:0]  b_val,
   output logic             redirect,
   output logic             want_link,
   output tgt_src_e         src_sel
);
   logic same;
   logic neg;
   logic zero;

   if (EQ_STYLE == 0) begin : g_eq_cmp
      assign same = (a_val == b_val);
   end else begin : g_eq_xor
      assign same = ~|(a_val ^ b_val);
   end

   assign neg  = a_val[XLEN-1];
   assign zero = ~|a_val;

   always_comb begin
      redirect  = 1'b0;
      want_link = 1'b0;
      src_sel   = SRC_SEQ;
      unique case (cls)
         FC_BEQ:     redirect = same;
         FC_BNE:     redirect = ~same;
         FC_GEZ:     redirect = ~neg;
         FC_GTZ:     redirect = ~neg & ~zero;
         FC_LEZ:     redirect = neg | zero;
         FC_LTZ:     redirect = neg;
         FC_GEZ_LK: begin
            redirect  = ~neg;
            want_link = ~neg;
         end
         FC_LTZ_LK: begin
            redirect  = neg;
            want_link = neg;
         end
         FC_JREG:    redirect = 1'b1;
         FC_JREG_LK: begin
            redirect  = 1'b1;
            want_link = 1'b1;
         end
         FC_JIND:    redirect = 1'b1;
         FC_JIND_LK: begin
            redirect  = 1'b1;
            want_link = 1'b1;
         end
         default: ;
      endcase
      if (redirect) begin
         if (cls == FC_JREG || cls == FC_JREG_LK)      src_sel = SRC_REGN;
         else if (cls == FC_JIND || cls == FC_JIND_LK) src_sel = SRC_IND;
         else                                          src_sel = SRC_REL;
      end
   end

   always_comb begin
      // R2
      beq_match_chk: assert (!(cls == FC_BEQ && redirect) || (a_val == b_val));
      // R3
      ltz_sign_chk: assert (!((cls == FC_LTZ || cls == FC_LTZ_LK) && redirect) || $signed(a_val) < 0);
      // R9
      link_needs_redirect_chk: assert (!want_link || redirect);
   end
endmodule

// File: rtl/nextpc_target.sv
module nextpc_target
   import nextpc_pkg::*;
#(
   parameter int XLEN  = 32,
   parameter int OFF_W = 16,
   parameter int IDX_W = 26
) (
   input  logic [XLEN-1:0]  cur_pc,
   input  logic [XLEN-1:0]  reg_tgt,
   input  logic [OFF_W-1:0] off,
   input  logic [IDX_W-1:0] idx,
   input  tgt_src_e         src_sel,
   output logic [XLEN-1:0]  seq_pc,
   output logic [XLEN-1:0]  dest_pc
);
   localparam int HI_W  = XLEN - IDX_W - 2;
   localparam int EXT_W = XLEN - OFF_W - 2;

   if (HI_W < 1) begin : g_bad_idx
      $error("nextpc_target: IDX_W too wide for XLEN");
   end
   if (EXT_W < 1) begin : g_bad_off
      $error("nextpc_target: OFF_W too wide for XLEN");
   end

   logic [XLEN-1:0] rel_disp;
   logic [XLEN-1:0] rel_pc;
   logic [XLEN-1:0] region_pc;

   assign seq_pc    = cur_pc + XLEN'(4);
   assign rel_disp  = {{EXT_W{off[OFF_W-1]}}, off, 2'b00};
   assign rel_pc    = seq_pc + rel_disp;
   assign region_pc = {seq_pc[XLEN-1 -: HI_W], idx, 2'b00};

   always_comb begin
      unique case (src_sel)
         SRC_REL:  dest_pc = rel_pc;
         SRC_REGN: dest_pc = region_pc;
         SRC_IND:  dest_pc = reg_tgt;
         default:  dest_pc = seq_pc;
      endcase
   end

   always_comb begin
      // R6
      region_keep_chk: assert (src_sel != SRC_REGN || dest_pc[XLEN-1 -: HI_W] == seq_pc[XLEN-1 -: HI_W]);
      // R4
      rel_align_chk: assert (src_sel != SRC_REL || dest_pc[1:0] == cur_pc[1:0]);
   end
endmodule

// File: rtl/nextpc_unit.sv
module nextpc_unit
   import nextpc_pkg::*;
#(
   parameter int XLEN     = 32,
   parameter int OFF_W    = 16,
   parameter int IDX_W    = 26,
   parameter int EQ_STYLE = 0
) (
   input  logic [XLEN-1:0]  pc,
   input  logic [3:0]       flow_cls,
   input  logic [XLEN-1:0]  rs_val,
   input  logic [XLEN-1:0]  rt_val,
   input  logic [OFF_W-1:0] br_off,
   input  logic [IDX_W-1:0] jmp_idx,
   output logic [XLEN-1:0]  next_pc,
   output logic             taken,
   output logic             link_we,
   output logic [XLEN-1:0]  link_data
);
   if (XLEN < 8) begin : g_bad_xlen
      $error("nextpc_unit: XLEN too small");
   end

   flow_cls_e       cls;
   tgt_src_e        src_sel;
   logic            redirect;
   logic            want_link;
   logic [XLEN-1:0] seq_pc;
   logic [XLEN-1:0] dest_pc;

   assign cls = flow_cls_e'(flow_cls);

   nextpc_cond #(.XLEN(XLEN), .EQ_STYLE(EQ_STYLE)) u_cond (
      .cls       (cls),
      .a_val     (rs_val),
      .b_val     (rt_val),
      .redirect  (redirect),
      .want_link (want_link),
      .src_sel   (src_sel)
   );

   nextpc_target #(.XLEN(XLEN), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_tgt (
      .cur_pc  (pc),
      .reg_tgt (rs_val),
      .off     (br_off),
      .idx     (jmp_idx),
      .src_sel (src_sel),
      .seq_pc  (seq_pc),
      .dest_pc (dest_pc)
   );

   assign next_pc   = dest_pc;
   assign taken     = redirect;
   assign link_we   = want_link;
   assign link_data = seq_pc;

   always_comb begin
      // R5
      untaken_seq_chk: assert (taken || next_pc == pc + XLEN'(4));
      // R8
      link_value_chk: assert (!link_we || link_data == pc + XLEN'(4));
   end
endmodule

// File: tb/nextpc_unit_bench.sv
module nextpc_unit_bench;
   typedef struct packed {
      logic [3:0]  cls;
      logic [31:0] pc;
      logic [31:0] rs;
      logic [31:0] rt;
      logic [15:0] off;
      logic [25:0] idx;
      logic [31:0] exp_pc;
      logic        exp_tk;
      logic        exp_lk;
   } vec_t;

   localparam int NV = 25;
   localparam vec_t VT [NV] = '{
      '{4'd1, 32'h00001000, 32'h5, 32'h5, 16'h0010, 26'h0, 32'h00001044, 1'b1, 1'b0},
      '{4'd1, 32'h00001000, 32'h5, 32'h6, 16'h0010, 26'h0, 32'h00001004, 1'b0, 1'b0},
      '{4'd2, 32'h00001000, 32'h5, 32'h6, 16'hFFFF, 26'h0, 32'h00001000, 1'b1, 1'b0},
      '{4'd2, 32'h00001000, 32'h5, 32'h5, 16'hFFFF, 26'h0, 32'h00001004, 1'b0, 1'b0},
      '{4'd1, 32'h00040000, 32'h0, 32'h0, 16'h8000, 26'h0, 32'h00020004, 1'b1, 1'b0},
      '{4'd1, 32'h00000000, 32'h0, 32'h0, 16'h7FFF, 26'h0, 32'h00020000, 1'b1, 1'b0},
      '{4'd3, 32'h00002000, 32'h0, 32'h0, 16'h0002, 26'h0, 32'h0000200C, 1'b1, 1'b0},
      '{4'd3, 32'h00002000, 32'h80000000, 32'h0, 16'h0002, 26'h0, 32'h00002004, 1'b0, 1'b0},
      '{4'd4, 32'h00002000, 32'h0, 32'h0, 16'h0002, 26'h0, 32'h00002004, 1'b0, 1'b0},
      '{4'd4, 32'h00002000, 32'h1, 32'h0, 16'h0002, 26'h0, 32'h0000200C, 1'b1, 1'b0},
      '{4'd5, 32'h00002000, 32'h0, 32'h0, 16'h0002, 26'h0, 32'h0000200C, 1'b1, 1'b0},
      '{4'd5, 32'h00002000, 32'h7FFFFFFF, 32'h0, 16'h0002, 26'h0, 32'h00002004, 1'b0, 1'b0},
      '{4'd6, 32'h00002000, 32'hFFFFFFFF, 32'h0, 16'h0002, 26'h0, 32'h0000200C, 1'b1, 1'b0},
      '{4'd6, 32'h00002000, 32'h0, 32'h0, 16'h0002, 26'h0, 32'h00002004, 1'b0, 1'b0},
      '{4'd7, 32'h00003000, 32'h7, 32'h0, 16'hFFFC, 26'h0, 32'h00002FF4, 1'b1, 1'b1},
      '{4'd7, 32'h00003000, 32'hFFFFFFF0, 32'h0, 16'hFFFC, 26'h0, 32'h00003004, 1'b0, 1'b0},
      '{4'd8, 32'h00003000, 32'h80000000, 32'h0, 16'h0004, 26'h0, 32'h00003014, 1'b1, 1'b1},
      '{4'd8, 32'h00003000, 32'h1, 32'h0, 16'h0004, 26'h0, 32'h00003004, 1'b0, 1'b0},
      '{4'd9, 32'hA0000100, 32'h0, 32'h0, 16'h0, 26'h0000040, 32'hA0000100, 1'b1, 1'b0},
      '{4'd10, 32'hF0001000, 32'h0, 32'h0, 16'h0, 26'h3FFFFFF, 32'hFFFFFFFC, 1'b1, 1'b1},
      '{4'd9, 32'h1FFFFFFC, 32'h0, 32'h0, 16'h0, 26'h0000010, 32'h20000040, 1'b1, 1'b0},
      '{4'd11, 32'h00000400, 32'h12345678, 32'h0, 16'h0, 26'h0, 32'h12345678, 1'b1, 1'b0},
      '{4'd12, 32'h00000400, 32'h00008000, 32'h0, 16'h0, 26'h0, 32'h00008000, 1'b1, 1'b1},
      '{4'd0, 32'h00000500, 32'h0, 32'h0, 16'h0040, 26'h0, 32'h00000504, 1'b0, 1'b0},
      '{4'd15, 32'h00000500, 32'h0, 32'h0, 16'h0040, 26'h3, 32'h00000504, 1'b0, 1'b0}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] pc = '0, rs_val = '0, rt_val = '0;
   logic [3:0]  flow_cls = '0;
   logic [15:0] br_off = '0;
   logic [25:0] jmp_idx = '0;
   logic [31:0] next_pc, link_data;
   logic        taken, link_we;
   int          n_chk = 0;
   int          n_bad = 0;
   bit          done = 1'b0;

   always #2 clk = ~clk;

   nextpc_unit u_nextpc_unit (
      .pc(pc), .flow_cls(flow_cls), .rs_val(rs_val), .rt_val(rt_val),
      .br_off(br_off), .jmp_idx(jmp_idx), .next_pc(next_pc), .taken(taken),
      .link_we(link_we), .link_data(link_data)
   );

   function automatic string tag_of(input logic [3:0] c);
      case (c)
         4'd1, 4'd2:         return "R2/R4/R5";
         4'd3, 4'd4, 4'd5, 4'd6: return "R3/R4/R5";
         4'd7, 4'd8:         return "R3/R8/R9";
         4'd9, 4'd10:        return "R6";
         4'd11, 4'd12:       return "R7";
         default:            return "R1";
      endcase
   endfunction

   task automatic cmp(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic apply(input vec_t v);
      @(posedge clk);
      flow_cls = v.cls; pc = v.pc; rs_val = v.rs; rt_val = v.rt;
      br_off = v.off; jmp_idx = v.idx;
      @(negedge clk);
      cmp(tag_of(v.cls), "next_pc", next_pc, v.exp_pc);
      cmp(tag_of(v.cls), "taken", {31'b0, taken}, {31'b0, v.exp_tk});
      cmp(v.cls inside {4'd7, 4'd8} ? "R9" : "R8", "link_we", {31'b0, link_we}, {31'b0, v.exp_lk});
      cmp("R8", "link_data", link_data, v.pc + 32'd4);
   endtask

   initial begin
      repeat (2) @(posedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: idle state after reset with all inputs zero
      cmp("R1", "idle next_pc", next_pc, 32'h4);
      cmp("R1", "idle taken", {31'b0, taken}, 32'h0);
      for (int i = 0; i < NV; i++) apply(VT[i]);
      // R8: sequential address wraps at the top of the space
      apply('{4'd0, 32'hFFFFFFFC, 32'h0, 32'h0, 16'h0, 26'h0, 32'h0, 1'b0, 1'b0});
      // R4: most negative offset from a low address wraps downward
      apply('{4'd2, 32'h00000000, 32'h1, 32'h0, 16'h8000, 26'h0, 32'hFFFE0004, 1'b1, 1'b0});
      // R6: region jump field ignores rs_val and br_off
      apply('{4'd10, 32'h5000000C, 32'hDEADBEEF, 32'h1, 16'hFFFF, 26'h0000001, 32'h50000004, 1'b1, 1'b1});
      // R7: register jump ignores the offset and index fields
      apply('{4'd11, 32'h00000100, 32'h00000002, 32'h0, 16'h7FFF, 26'h3FFFFFF, 32'h00000002, 1'b1, 1'b0});
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule